// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address for every beat of one SDRAM read or write burst. A mode-load strobe captures the burst configuration from a 10-bit address word. That configuration holds the beat count, the ordering (linear wrap or bitwise-XOR), the CAS latency and a flag that limits writes to one location. A column command then gives the starting column. From the next clock on, the block presents one column per cycle with a valid flag, and it raises a last flag on the closing beat of a finite burst.

A full-row burst walks all 256 columns of the row in linear order and wraps at the row's end. It keeps running until a stop strobe or a new column command ends it. A new column command is accepted on any cycle, including the cycle straight after a previous one. It drops the running burst at once and starts the new sequence on the following cycle.

The control is a three-state machine. IDLE means no burst is active. BURST means a finite burst is running. PAGE means a full-row burst is running. The transitions are:
- START: from any state into BURST or PAGE when a column command is sampled.
- FINISH: BURST back to IDLE after the closing beat.
- STOP: BURST or PAGE back to IDLE on a stop strobe with no column command.
- STEP: BURST or PAGE stays where it is and advances the beat counter.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, col_valid and col_last are 0 and cas_lat reads 3'b011. The reset configuration is: length 1, linear order, burst writes.
- R2: A mode load captures mode_addr. Bits [2:0] select the length: 000=1, 001=2, 010=4, 011=8, 111=full row; the codes 100, 101 and 110 act as length 1. Bit 3 selects the order (0 linear, 1 XOR). Bits [6:4] appear on cas_lat from the next cycle. Bit 9 set limits writes to one location.
- R3: In the cycle after cmd_start is sampled, col_valid is 1 and col_addr equals cmd_col.
- R4: In linear order with length L, beat k outputs the start column with its low log2(L) bits replaced by (those low bits + k) mod L. The upper bits stay unchanged.
- R5: In XOR order with length L, beat k outputs the start column with its low log2(L) bits XORed with k.
- R6: col_last is 1 only on beat L-1 of a finite burst. In the following cycle col_valid is 0 unless a new command was sampled.
- R7: A full-row burst advances col_addr by 1 modulo 256 each cycle and never raises col_last. If XOR order is configured together with full row, the burst uses linear order.
- R8: With bit 9 set, a write command (cmd_write=1) gives a one-beat burst, while reads keep the programmed length.
- R9: A cmd_start sampled during a burst abandons it. The next cycle shows the new cmd_col as beat 0.
- R10: A cmd_stop sampled without cmd_start makes col_valid 0 in the next cycle. If both are sampled together, the start wins.
- R11: A mode load during a burst does not change that burst. Length, order and write limit are fixed when the burst starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Capture mode_addr as the new configuration |
| mode_addr | input | 10 | Configuration word |
| cmd_start | input | 1 | Column command strobe |
| cmd_write | input | 1 | Command is a write (1) or a read (0) |
| cmd_col | input | 8 | Starting column of the command |
| cmd_stop | input | 1 | Terminate the running burst |
| col_addr | output | 8 | Column address of the current beat |
| col_valid | output | 1 | col_addr is a beat of an active burst |
| col_last | output | 1 | Closing beat of a finite burst |
| cas_lat | output | 3 | Configured CAS latency field |

## Verification
A beat counter that is wrong shows up as a bad col_addr on the very next beat. It also shows as col_last appearing on the wrong cycle, or valid being held one cycle too long or dropped one cycle too early. A mask latched from the wrong length disturbs the upper address bits or the wrap point within the first L beats. A state machine stuck in PAGE would never release col_valid without a stop. Every output is compared on every cycle against a bench model, so such errors are caught within one cycle of diverging. Random mode loads, back-to-back commands and stops exercise the restart and priority paths.

// File: rtl/sbcg_pkg.sv
package sbcg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_PAGE  = 2'd2
    } burst_state_e;

    typedef struct packed {
        logic [2:0] len_code;
        logic       interleave;
        logic [2:0] cas;
        logic       single_wr;
    } mode_t;

    localparam logic [2:0] LEN_CODE_1    = 3'b000;
    localparam logic [2:0] LEN_CODE_2    = 3'b001;
    localparam logic [2:0] LEN_CODE_4    = 3'b010;
    localparam logic [2:0] LEN_CODE_8    = 3'b011;
    localparam logic [2:0] LEN_CODE_PAGE = 3'b111;

endpackage

// File: rtl/sbcg_mode_reg.sv
module sbcg_mode_reg
    import sbcg_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] word,
    output mode_t             mode_q
);
    localparam int LEN_LO = 0;
    localparam int ORD_B  = 3;
    localparam int CAS_LO = 4;
    localparam int WS_B   = 9;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q.len_code   <= LEN_CODE_1;
            mode_q.interleave <= 1'b0;
            mode_q.cas        <= 3'b011;
            mode_q.single_wr  <= 1'b0;
        end else if (load) begin
            mode_q.len_code   <= word[LEN_LO+2:LEN_LO];
            mode_q.interleave <= word[ORD_B];
            mode_q.cas        <= word[CAS_LO+2:CAS_LO];
            mode_q.single_wr  <= word[WS_B];
        end
    end

    // R2: the latency field follows the loaded word one cycle later
    p_load_cas_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> mode_q.cas == $past(word[CAS_LO+2:CAS_LO]));

endmodule

// File: rtl/sbcg_addr_gen.sv
module sbcg_addr_gen #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  logic             xor_order,
    output logic [COL_W-1:0] addr
);
    logic [COL_W-1:0] lin_sum;
    assign lin_sum = base + beat;

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        always_comb begin
            if (mask[i])
                addr[i] = xor_order ? (base[i] ^ beat[i]) : lin_sum[i];
            else
                addr[i] = base[i];
        end
    end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import sbcg_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int MODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_addr,
    input  logic              cmd_start,
    input  logic              cmd_write,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              cmd_stop,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_valid,
    output logic              col_last,
    output logic [2:0]        cas_lat
);
    localparam int SH_W = $clog2(COL_W + 1);
    localparam logic [COL_W-1:0] ONE = {{(COL_W-1){1'b0}}, 1'b1};

    mode_t            mode_q;
    burst_state_e     state_q, state_d;
    logic [COL_W-1:0] base_q, base_d;
    logic [COL_W-1:0] beat_q, beat_d;
    logic [COL_W-1:0] mask_q, mask_d;
    logic             xor_q, xor_d;

    logic [SH_W-1:0]  new_sh;
    logic             new_page;
    logic             new_xor;
    logic [COL_W-1:0] new_mask;

    sbcg_mode_reg #(.ADDR_W(MODE_W)) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (mode_load),
        .word   (mode_addr),
        .mode_q (mode_q)
    );

    // burst shape decided at the command, from the configuration in force
    always_comb begin
        new_page = 1'b0;
        unique case (mode_q.len_code)
            LEN_CODE_2:    new_sh = SH_W'(1);
            LEN_CODE_4:    new_sh = SH_W'(2);
            LEN_CODE_8:    new_sh = SH_W'(3);
            LEN_CODE_PAGE: begin
                new_sh   = SH_W'(COL_W);
                new_page = 1'b1;
            end
            default:       new_sh = '0;
        endcase
        if (cmd_write && mode_q.single_wr) begin
            new_sh   = '0;
            new_page = 1'b0;
        end
        new_xor  = mode_q.interleave && !new_page;
        new_mask = ~({COL_W{1'b1}} << new_sh);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        beat_d  = beat_q;
        mask_d  = mask_q;
        xor_d   = xor_q;
        if (cmd_start) begin
            state_d = new_page ? ST_PAGE : ST_BURST;
            base_d  = cmd_col;
            beat_d  = '0;
            mask_d  = new_mask;
            xor_d   = new_xor;
        end else if (cmd_stop) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  ;
                ST_BURST: begin
                    if (beat_q == mask_q) state_d = ST_IDLE;
                    else                  beat_d  = beat_q + ONE;
                end
                ST_PAGE:  beat_d = beat_q + ONE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            beat_q  <= '0;
            mask_q  <= '0;
            xor_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            base_q  <= base_d;
            beat_q  <= beat_d;
            mask_q  <= mask_d;
            xor_q   <= xor_d;
        end
    end

    sbcg_addr_gen #(.COL_W(COL_W)) u_addr (
        .base      (base_q),
        .beat      (beat_q),
        .mask      (mask_q),
        .xor_order (xor_q),
        .addr      (col_addr)
    );

    // outputs
    always_comb begin
        col_valid = (state_q != ST_IDLE);
        col_last  = (state_q == ST_BURST) && (beat_q == mask_q);
        cas_lat   = mode_q.cas;
    end

    p_start_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> col_valid && col_addr == $past(cmd_col));

    p_upper_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && !col_last && !cmd_start && !cmd_stop
        |=> (col_addr & ~$past(mask_q)) == ($past(col_addr) & ~$past(mask_q)));

    p_last_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);

    p_last_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        col_last && !cmd_start |=> !col_valid);

    p_page_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_PAGE && !cmd_start && !cmd_stop
        |=> col_valid && col_addr == $past(col_addr) + ONE);

    p_single_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start && cmd_write && mode_q.single_wr |=> col_last);

    p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop && !cmd_start |=> !col_valid);

endmodule

// File: tb/tb_sdram_burst_colgen.sv
module tb_sdram_burst_colgen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_load = 1'b0;
    logic [9:0] mode_addr = '0;
    logic       cmd_start = 1'b0;
    logic       cmd_write = 1'b0;
    logic [7:0] cmd_col = '0;
    logic       cmd_stop = 1'b0;
    logic [7:0] col_addr;
    logic       col_valid;
    logic       col_last;
    logic [2:0] cas_lat;

    sdram_burst_colgen dut (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_addr(mode_addr),
        .cmd_start(cmd_start), .cmd_write(cmd_write), .cmd_col(cmd_col),
        .cmd_stop(cmd_stop), .col_addr(col_addr), .col_valid(col_valid),
        .col_last(col_last), .cas_lat(cas_lat)
    );

    always #5 clk = ~clk;

    int    n_chk = 0;
    int    n_fail = 0;
    string tag = "R1";
    bit    checking = 1'b0;
    bit    done = 1'b0;

    // bench model of the requirements
    int m_code = 0, m_cas = 3;
    bit m_ilv_cfg = 0, m_ws = 0;
    bit m_act = 0, m_page = 0, m_ilv = 0;
    int m_base = 0, m_k = 0, m_len = 1;

    function automatic int dec_len(int code);
        case (code)
            1: return 2;
            2: return 4;
            3: return 8;
            7: return 256;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_addr(int base, int k, int len, bit ilv);
        int low;
        if (ilv) return base ^ k;
        low = base % len;
        return base - low + ((low + k) % len);
    endfunction

    function automatic logic [9:0] mk_mode(int code, bit ilv, int cas, bit ws);
        return {ws, 2'b00, 3'(cas), ilv, 3'(code)};
    endfunction

    task automatic chk(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_code = 0; m_ilv_cfg = 0; m_cas = 3; m_ws = 0;
        end else begin
            if (cmd_start) begin
                m_act = 1; m_base = cmd_col; m_k = 0;
                if (cmd_write && m_ws) begin
                    m_len = 1; m_page = 0;
                end else begin
                    m_len = dec_len(m_code); m_page = (m_code == 7);
                end
                m_ilv = m_ilv_cfg && !m_page;
            end else if (cmd_stop) begin
                m_act = 0;
            end else if (m_act) begin
                if (!m_page && m_k == m_len - 1) m_act = 0;
                else m_k = (m_k + 1) % 256;
            end
            if (mode_load) begin
                m_code = mode_addr[2:0]; m_ilv_cfg = mode_addr[3];
                m_cas = mode_addr[6:4]; m_ws = mode_addr[9];
            end
        end
    end

    always @(posedge clk) begin
        #3;
        if (checking && rst_n && !done) begin
            chk("valid", col_valid, m_act);
            if (m_act) begin
                chk("addr", col_addr, exp_addr(m_base, m_k, m_len, m_ilv));
                chk("last", col_last, !m_page && m_k == m_len - 1);
            end else begin
                chk("last", col_last, 0);
            end
            chk("cas_lat (R2)", cas_lat, m_cas);
        end
    end

    task automatic load_mode(int code, bit ilv, int cas, bit ws);
        @(negedge clk);
        mode_load = 1; mode_addr = mk_mode(code, ilv, cas, ws);
        cmd_start = 0; cmd_stop = 0;
        @(negedge clk);
        mode_load = 0;
    endtask

    task automatic start_burst(int col, bit wr);
        @(negedge clk);
        cmd_start = 1; cmd_col = 8'(col); cmd_write = wr; cmd_stop = 0;
        @(negedge clk);
        cmd_start = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        tag = "R1";
        chk("reset valid", col_valid, 0);
        chk("reset last", col_last, 0);
        chk("reset cas_lat", cas_lat, 3);
        checking = 1;

        // R1: reset configuration gives one-beat bursts
        tag = "R1"; start_burst(8'h44, 0); idle(3);

        // R2: reserved length code acts as length 1, latency field captured
        tag = "R2"; load_mode(5, 0, 2, 0); start_burst(8'h17, 0); idle(3);

        // R4: linear length 4 from 0x3E: 3E 3F 3C 3D
        tag = "R4"; load_mode(2, 0, 3, 0); start_burst(8'h3E, 0); idle(6);
        tag = "R4"; load_mode(3, 0, 3, 0); start_burst(8'hC5, 1); idle(10);
        tag = "R4"; load_mode(1, 0, 3, 0); start_burst(8'h81, 0); idle(4);

        // R5: XOR length 8 from 0x25: 25 24 27 26 21 20 23 22
        tag = "R5"; load_mode(3, 1, 2, 0); start_burst(8'h25, 0); idle(10);
        tag = "R5"; load_mode(2, 1, 2, 0); start_burst(8'h9A, 1); idle(6);

        // R6: closing beat of a length-8 burst then valid falls
        tag = "R6"; load_mode(3, 0, 3, 0); start_burst(8'h07, 0); idle(10);

        // R7: full row wraps past 0xFF and never flags last
        tag = "R7"; load_mode(7, 0, 3, 0); start_burst(8'hFE, 0); idle(300);
        tag = "R10"; @(negedge clk); cmd_stop = 1; @(negedge clk); cmd_stop = 0; idle(3);
        tag = "R7"; load_mode(7, 1, 3, 0); start_burst(8'h10, 0); idle(20);
        tag = "R10"; @(negedge clk); cmd_stop = 1; @(negedge clk); cmd_stop = 0; idle(2);

        // R8: single-location writes, reads keep length 8
        tag = "R8"; load_mode(3, 0, 3, 1); start_burst(8'h50, 1); idle(3);
        tag = "R8"; start_burst(8'h50, 0); idle(10);

        // R9: back-to-back commands restart at once
        tag = "R9"; load_mode(3, 0, 3, 0); start_burst(8'h20, 0); idle(2);
        start_burst(8'h64, 0); start_burst(8'hA3, 1); idle(10);

        // R10: stop and start together, start wins
        tag = "R10"; start_burst(8'h30, 0); idle(1);
        @(negedge clk); cmd_start = 1; cmd_stop = 1; cmd_col = 8'h6B;
        @(negedge clk); cmd_start = 0; cmd_stop = 0; idle(10);

        // R11: configuration change mid-burst leaves the burst alone
        tag = "R11"; start_burst(8'h88, 0); load_mode(1, 1, 2, 1); idle(10);

        // random mix
        tag = "R9";
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            mode_load = ($urandom % 20) == 0;
            begin
                int codes[6] = '{0, 1, 2, 3, 7, 6};
                mode_addr = mk_mode(codes[$urandom % 6], 1'($urandom), 2 + ($urandom % 2),
                                    ($urandom % 3) == 0);
            end
            cmd_start = ($urandom % 5) == 0;
            cmd_stop  = ($urandom % 17) == 0;
            cmd_write = 1'($urandom);
            cmd_col   = 8'($urandom);
        end
        @(negedge clk);
        mode_load = 0; cmd_start = 0; cmd_stop = 1;
        @(negedge clk);
        cmd_stop = 0;
        idle(3);
        finish_run();
    end

endmodule